// File: doc/BRIEF.md
# Watchdog Timer with Grace Window and Timed System Reset

The block is a watchdog that runs on a single watchdog clock. While enabled, an 18-bit up counter advances by one on every clock. Each time the counter crosses the boundary chosen by a 3-bit interval select, the watchdog raises an interrupt flag. The first such time-out does not reset the chip. It opens a grace window of 1024 clocks, and software may service the watchdog during that window by pulsing the counter-clear strobe. If the window closes without service and reset generation is enabled, the watchdog sets a sticky reset-cause flag and drives a system reset pulse that lasts exactly 63 clocks.

The control side is a set of register-style inputs: enable, interval select, interrupt enable, reset enable, a one-cycle counter-clear strobe, and write-one-to-clear strobes for the two flags. The flags and the two event outputs are read back directly. A power-on reset input clears all state, and it is the only reset that clears the reset-cause flag apart from its own clear strobe.

Control is a four-state machine. In OFF the watchdog is disabled and the counter holds its value. In COUNT the counter runs and no window is open. In GRACE the counter keeps running while the grace window is timed. In RESET the system reset pulse is driven. The transitions are:
- OFF→COUNT when the block is enabled.
- OFF→GRACE when it is enabled and the held count sits one below a boundary.
- COUNT→GRACE on a time-out.
- COUNT→OFF and GRACE→OFF when the enable is dropped.
- GRACE→COUNT on a counter clear, or when the window ends while reset generation is disabled.
- GRACE→RESET when the window ends unserviced while reset generation is enabled.
- RESET→COUNT or RESET→OFF when the pulse ends, depending on the enable.

Top module: `wdog_guard`

## Requirements
- R1: After power-on reset (`por_n` low), `irq_flag`, `rst_flag`, `irq` and `sys_rst` are all 0.
- R2: The counter advances only on clocks where `run_en` is 1. While `run_en` is 0 the count is held and no time-out occurs. Dropping `run_en` during the grace window cancels the window.
- R3: With `ivl_sel` = n (0 to 7), the interrupt flag is set on the clock edge at which the counter reaches a multiple of 2^(4+2n). From a zero count this is the 2^(4+2n)-th enabled clock. The time-out repeats every 2^(4+2n) clocks, and the counter wraps at 2^18.
- R4: `irq` equals `irq_flag` gated by `irq_en`.
- R5: A 1 on `irq_flag_clr` clears the interrupt flag on the next edge. If a time-out falls on the same edge, the set wins.
- R6: A 1 on `kick`, sampled at an edge, zeroes the counter at that edge. The next time-out then comes a full interval later.
- R7: The first time-out opens a grace window. If neither `kick` nor a drop of `run_en` occurs and `rst_en` is 1, then `rst_flag` and `sys_rst` both become 1 on the 1024th edge after the edge that set the interrupt flag.
- R8: A `kick` sampled on any edge of the grace window, the last one included, cancels the pending reset.
- R9: `sys_rst` stays 1 for exactly 63 clocks and then returns to 0.
- R10: `rst_flag` stays 1 through and after the reset pulse. Only `rst_flag_clr` or `por_n` clears it.
- R11: If the grace window ends while `rst_en` is 0, no reset pulse is issued, and the counter keeps running with periodic time-outs.
- R12: On the edge that starts the reset pulse, the counter and the interrupt flag are zeroed. The next time-out comes one full interval after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| run_en | input | 1 | Watchdog enable; the counter runs while 1 |
| ivl_sel | input | 3 | Interval select n, time-out every 2^(4+2n) clocks |
| irq_en | input | 1 | Interrupt output enable |
| rst_en | input | 1 | Allows the reset pulse when the grace window ends |
| kick | input | 1 | Counter-clear strobe, one clock wide |
| irq_flag_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| rst_flag_clr | input | 1 | Write-one-to-clear strobe for the reset-cause flag |
| irq_flag | output | 1 | Time-out interrupt flag |
| rst_flag | output | 1 | Sticky reset-cause flag |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
The time-out is exercised with three interval selects and sampled one clock before and on the expected edge, so that an off-by-one or a wrong exponent shows. Enabled counting is interrupted by a pause and by a counter clear, which separates a counter that holds from one that keeps running and from one that is not zeroed. The grace window is run in four ways: unserviced with reset enabled, serviced on its very last edge, serviced partway through, and unserviced with reset disabled. These runs tell apart an early or late reset, a clear that misses the boundary edge, and a reset issued against the enable. The reset pulse is timed to the clock at both ends, and the cause flag is followed through the pulse, its clear strobe and power-on reset.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

    // Control states of the watchdog
    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_COUNT = 2'b01,
        ST_GRACE = 2'b10,
        ST_RESET = 2'b11
    } wd_state_t;

    // Exponent of the time-out interval for one select value, limited to the counter width
    function automatic int unsigned ivl_exp(input int unsigned sel, input int unsigned base,
                                            input int unsigned step, input int unsigned width);
        int unsigned raw;
        raw = base + step * sel;
        return (raw > width) ? width : raw;
    endfunction

endpackage

// File: rtl/wdog_upcount.sv
module wdog_upcount
    import wdog_guard_pkg::*;
#(
    parameter int unsigned CNT_W    = 18,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 4,
    parameter int unsigned EXP_STEP = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             inc,
    input  logic             zero,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [NSEL-1:0]  wrap_at;

    // One boundary detector per interval: all low bits set means the next step crosses it
    for (genvar g = 0; g < NSEL; g++) begin : g_ivl
        localparam int unsigned EXPN = ivl_exp(g, BASE_EXP, EXP_STEP, CNT_W);
        assign wrap_at[g] = &cnt_q[EXPN-1:0];
    end

    // A clear strobe takes priority over a boundary crossing
    assign tick = inc && !zero && wrap_at[sel];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (zero) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_span.sv
module wdog_span #(
    parameter int unsigned LEN = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic clr,
    output logic last
);
    localparam int unsigned W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST_VAL = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Marks the final clock of a span of LEN clocks while run is held
    assign last = run && (cnt_q == LAST_VAL);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!run || clr || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_guard_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic run_en,
    input  logic rst_en,
    input  logic kick,
    input  logic tick,
    input  logic grace_last,
    input  logic pulse_last,
    output logic cnt_inc,
    output logic cnt_zero,
    output logic enter_rst,
    output logic in_grace,
    output logic in_reset
);
    wd_state_t state_q;
    wd_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en) begin
                    state_d = tick ? ST_GRACE : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!run_en) begin
                    state_d = ST_OFF;
                end else if (tick) begin
                    state_d = ST_GRACE;
                end
            end
            ST_GRACE: begin
                if (!run_en) begin
                    state_d = ST_OFF;
                end else if (kick) begin
                    state_d = ST_COUNT;
                end else if (grace_last) begin
                    state_d = rst_en ? ST_RESET : (tick ? ST_GRACE : ST_COUNT);
                end
            end
            ST_RESET: begin
                if (pulse_last) begin
                    state_d = run_en ? ST_COUNT : ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        in_grace  = (state_q == ST_GRACE);
        in_reset  = (state_q == ST_RESET);
        cnt_inc   = run_en && (state_q != ST_RESET);
        enter_rst = (state_q == ST_GRACE) && run_en && !kick && grace_last && rst_en;
        cnt_zero  = kick || enter_rst;
    end

endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
    input  logic clk,
    input  logic por_n,
    input  logic irq_set,
    input  logic irq_drop,
    input  logic irq_clr,
    input  logic rst_set,
    input  logic rst_clr,
    output logic irq_flag,
    output logic rst_flag
);
    // Time-out flag: set has priority over the software clear, the reset entry wipes it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq_flag <= 1'b0;
        end else if (irq_drop) begin
            irq_flag <= 1'b0;
        end else if (irq_set) begin
            irq_flag <= 1'b1;
        end else if (irq_clr) begin
            irq_flag <= 1'b0;
        end
    end

    // Reset-cause flag: only power-on reset or its own clear strobe removes it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_flag <= 1'b0;
        end else if (rst_set) begin
            rst_flag <= 1'b1;
        end else if (rst_clr) begin
            rst_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned BASE_EXP  = 4,
    parameter int unsigned EXP_STEP  = 2,
    parameter int unsigned DLY_LEN   = 1024,
    parameter int unsigned PULSE_LEN = 63
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] ivl_sel,
    input  logic             irq_en,
    input  logic             rst_en,
    input  logic             kick,
    input  logic             irq_flag_clr,
    input  logic             rst_flag_clr,
    output logic             irq_flag,
    output logic             rst_flag,
    output logic             irq,
    output logic             sys_rst
);
    logic tick;
    logic cnt_inc;
    logic cnt_zero;
    logic enter_rst;
    logic in_grace;
    logic in_reset;
    logic grace_last;
    logic pulse_last;

    wdog_upcount #(
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .BASE_EXP(BASE_EXP),
        .EXP_STEP(EXP_STEP)
    ) u_count (
        .clk  (clk),
        .por_n(por_n),
        .inc  (cnt_inc),
        .zero (cnt_zero),
        .sel  (ivl_sel),
        .tick (tick)
    );

    wdog_span #(.LEN(DLY_LEN)) u_grace (
        .clk  (clk),
        .por_n(por_n),
        .run  (in_grace),
        .clr  (kick),
        .last (grace_last)
    );

    wdog_span #(.LEN(PULSE_LEN)) u_pulse (
        .clk  (clk),
        .por_n(por_n),
        .run  (in_reset),
        .clr  (1'b0),
        .last (pulse_last)
    );

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .run_en    (run_en),
        .rst_en    (rst_en),
        .kick      (kick),
        .tick      (tick),
        .grace_last(grace_last),
        .pulse_last(pulse_last),
        .cnt_inc   (cnt_inc),
        .cnt_zero  (cnt_zero),
        .enter_rst (enter_rst),
        .in_grace  (in_grace),
        .in_reset  (in_reset)
    );

    wdog_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .irq_set (tick),
        .irq_drop(enter_rst),
        .irq_clr (irq_flag_clr),
        .rst_set (enter_rst),
        .rst_clr (rst_flag_clr),
        .irq_flag(irq_flag),
        .rst_flag(rst_flag)
    );

    assign irq     = irq_flag && irq_en;
    assign sys_rst = in_reset;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int unsigned PULSE_LEN = 63
) (
    input logic clk,
    input logic por_n,
    input logic run_en,
    input logic irq_flag_clr,
    input logic rst_flag_clr,
    input logic irq_flag,
    input logic rst_flag,
    input logic sys_rst
);
    logic [15:0] hi_cnt;

    // Length of the current reset pulse in clocks
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_cnt <= '0;
        end else if (sys_rst) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    AST_IDLE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
        (!run_en && !irq_flag) |=> !irq_flag); // R2

    AST_IRQ_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (irq_flag && !irq_flag_clr) |=> (irq_flag || sys_rst)); // R5

    AST_RESET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> rst_flag); // R7

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (hi_cnt == 16'(PULSE_LEN))); // R9

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (rst_flag && !rst_flag_clr) |=> rst_flag); // R10

endmodule

bind wdog_guard wdog_guard_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .run_en      (run_en),
    .irq_flag_clr(irq_flag_clr),
    .rst_flag_clr(rst_flag_clr),
    .irq_flag    (irq_flag),
    .rst_flag    (rst_flag),
    .sys_rst     (sys_rst)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
    localparam int GRACE = 1024;
    localparam int PULSE = 63;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] ivl_sel = 3'd0;
    logic       irq_en = 1'b0;
    logic       rst_en = 1'b0;
    logic       kick = 1'b0;
    logic       irq_flag_clr = 1'b0;
    logic       rst_flag_clr = 1'b0;
    logic       irq_flag;
    logic       rst_flag;
    logic       irq;
    logic       sys_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdog_guard u_wdog_guard (
        .clk         (clk),
        .por_n       (por_n),
        .run_en      (run_en),
        .ivl_sel     (ivl_sel),
        .irq_en      (irq_en),
        .rst_en      (rst_en),
        .kick        (kick),
        .irq_flag_clr(irq_flag_clr),
        .rst_flag_clr(rst_flag_clr),
        .irq_flag    (irq_flag),
        .rst_flag    (rst_flag),
        .irq         (irq),
        .sys_rst     (sys_rst)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_por();
        por_n = 1'b0;
        run_en = 1'b0; ivl_sel = 3'd0; irq_en = 1'b0; rst_en = 1'b0;
        kick = 1'b0; irq_flag_clr = 1'b0; rst_flag_clr = 1'b0;
        step(3);
        por_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state();
        do_por();
        chk("R1", "irq_flag", irq_flag, 0);
        chk("R1", "rst_flag", rst_flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "sys_rst", sys_rst, 0);
    endtask

    task automatic t_interval(input int s);
        int n;
        n = 1 << (4 + 2 * s);
        do_por();
        ivl_sel = 3'(s);
        run_en = 1'b1;
        step(n - 1);
        chk("R3", "flag one clock early", irq_flag, 0);
        step(1);
        chk("R3", "flag on boundary", irq_flag, 1);
        run_en = 1'b0;
    endtask

    task automatic t_pause();
        do_por();
        run_en = 1'b1;
        step(8);
        run_en = 1'b0;
        step(20);
        chk("R2", "no time-out while paused", irq_flag, 0);
        run_en = 1'b1;
        step(7);
        chk("R2", "held count resumes", irq_flag, 0);
        step(1);
        chk("R2", "time-out after 16 enabled clocks", irq_flag, 1);
        run_en = 1'b0;
    endtask

    task automatic t_kick();
        do_por();
        run_en = 1'b1;
        step(10);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        step(15);
        chk("R6", "no time-out before full interval", irq_flag, 0);
        step(1);
        chk("R6", "time-out one interval after clear", irq_flag, 1);
        run_en = 1'b0;
    endtask

    task automatic t_flag_w1c();
        do_por();
        run_en = 1'b1;
        step(15);
        irq_flag_clr = 1'b1;
        step(1);
        irq_flag_clr = 1'b0;
        chk("R5", "set beats clear", irq_flag, 1);
        chk("R4", "irq gated off", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R4", "irq gated on", irq, 1);
        irq_flag_clr = 1'b1;
        step(1);
        irq_flag_clr = 1'b0;
        chk("R5", "flag cleared", irq_flag, 0);
        chk("R4", "irq follows flag", irq, 0);
        run_en = 1'b0;
    endtask

    task automatic t_grace_reset();
        do_por();
        rst_en = 1'b1;
        run_en = 1'b1;
        step(16);
        chk("R7", "first time-out flag", irq_flag, 1);
        step(GRACE - 1);
        chk("R7", "no reset before window end", sys_rst, 0);
        chk("R7", "no cause before window end", rst_flag, 0);
        step(1);
        chk("R7", "reset at window end", sys_rst, 1);
        chk("R7", "cause set with reset", rst_flag, 1);
        chk("R12", "irq flag wiped on reset entry", irq_flag, 0);
        step(PULSE - 1);
        chk("R9", "pulse on last clock", sys_rst, 1);
        step(1);
        chk("R9", "pulse released", sys_rst, 0);
        chk("R10", "cause survives pulse", rst_flag, 1);
        step(15);
        chk("R12", "count restarted from zero", irq_flag, 0);
        step(1);
        chk("R12", "time-out one interval after pulse", irq_flag, 1);
        run_en = 1'b0;
        step(5);
        chk("R10", "cause still held", rst_flag, 1);
        rst_flag_clr = 1'b1;
        step(1);
        rst_flag_clr = 1'b0;
        chk("R10", "cause cleared by strobe", rst_flag, 0);
    endtask

    task automatic t_por_clears();
        do_por();
        rst_en = 1'b1;
        run_en = 1'b1;
        step(16 + GRACE);
        chk("R10", "cause set again", rst_flag, 1);
        do_por();
        chk("R10", "cause cleared by power-on reset", rst_flag, 0);
        chk("R1", "pulse ended by power-on reset", sys_rst, 0);
    endtask

    task automatic t_kick_window();
        int hi;
        do_por();
        rst_en = 1'b1;
        run_en = 1'b1;
        step(16 + GRACE - 1);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        chk("R8", "clear on last window clock stops reset", sys_rst, 0);
        chk("R8", "no cause after last-clock clear", rst_flag, 0);
        // second window, serviced partway through
        step(16 + 500);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        hi = 0;
        for (int i = 0; i < GRACE - 100; i++) begin
            step(1);
            if (sys_rst) hi++;
        end
        chk("R8", "mid-window clear, reset clocks", hi, 0);
        chk("R8", "mid-window clear, cause", rst_flag, 0);
        run_en = 1'b0;
    endtask

    task automatic t_no_reset();
        int hi;
        do_por();
        run_en = 1'b1;
        step(16);
        chk("R11", "time-out flag", irq_flag, 1);
        irq_flag_clr = 1'b1;
        step(1);
        irq_flag_clr = 1'b0;
        chk("R11", "flag cleared", irq_flag, 0);
        step(14);
        chk("R11", "counter still running, before boundary", irq_flag, 0);
        step(1);
        chk("R11", "periodic time-out", irq_flag, 1);
        hi = 0;
        for (int i = 0; i < GRACE + 200; i++) begin
            step(1);
            if (sys_rst) hi++;
        end
        chk("R11", "reset clocks with reset disabled", hi, 0);
        chk("R11", "no cause with reset disabled", rst_flag, 0);
        run_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual over %0d clocks expected fewer", 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_interval(0);
        t_interval(1);
        t_interval(2);
        t_pause();
        t_kick();
        t_flag_w1c();
        t_grace_reset();
        t_por_clears();
        t_kick_window();
        t_no_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule